// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked system read and write one external asynchronous static RAM that holds 128K bytes. The user side is a single-request port. The user raises `req` together with a direction bit, a 17-bit address and, for a write, one data byte. The controller takes the request only while `rdy` is high. It then runs a fixed sequence of memory strobes and signals the end of the access with a one-clock `done` pulse. For a read, the fetched byte appears on `rdata` in that same cycle and stays there until the next read completes.

The memory has two chip selects of opposite polarity, a low-active write strobe and a low-active output enable. The bidirectional data bus is split into an outgoing byte, an incoming byte and a drive-enable. Access lengths are parameters in nanoseconds and are converted to clock counts from the clock period, rounded up. With the default 4 ns period a read holds output enable low for 3 clocks and a write holds the write strobe low for 3 clocks. Between accesses the memory is deselected and every address and data line is held still, so the part can settle into its lowest standby current.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and whenever idle, the outputs are `ce1_n`=1, `ce2`=0, `we_n`=1, `oe_n`=1, `dq_oe`=0, and `rdy`=1.
- R2: While idle, `sram_addr` and `sram_dq_out` do not change.
- R3: A read holds `ce1_n`=0, `ce2`=1, `we_n`=1 and `oe_n`=0 for exactly RD_CYC clocks, where RD_CYC = ceil(max(T_RC_NS, T_AA_NS)/CLK_PERIOD_NS) and is at least 1 (3 by default). The read samples `sram_dq_in` on the last of those clocks. `done` is seen RD_CYC+1 clocks after the accepting edge, and `rdata` then equals the stored byte.
- R4: A write runs as one setup clock (chip selected, `we_n`=1, `oe_n`=1, `dq_oe`=1), then WR_CYC = ceil(T_WC_NS/CLK_PERIOD_NS) clocks with `we_n`=0 (3 by default), then one hold clock with `we_n`=1 and `dq_oe`=1. The write data stays stable across the strobe. `done` follows WR_CYC+3 clocks after the accepting edge, and `dq_oe` is already 0 by then.
- R5: `sram_addr` does not change while the chip stays selected.
- R6: `dq_oe` is never 1 while `oe_n` is 0, nor in the clock right after one with `oe_n`=0. A write that immediately follows a read therefore sees at least one clock with output enable high before the bus is driven.
- R7: `done` lasts exactly one clock. `rdy` is 0 during an access, and a `req` raised during an access is ignored and leaves no effect on the memory.
- R8: `we_n` and `oe_n` are never low together.
- R9: `rdata` changes only when a read completes. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, taken only while `rdy` is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| rdy | output | 1 | Controller idle and able to accept a request |
| done | output | 1 | One-clock end-of-access pulse |
| rdata | output | 8 | Last byte read |
| sram_ce1_n | output | 1 | Chip select, active low |
| sram_ce2 | output | 1 | Chip select, active high |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | 17 | Memory address |
| sram_dq_out | output | 8 | Byte driven onto the data bus |
| sram_dq_in | input | 8 | Byte received from the data bus |
| sram_dq_oe | output | 1 | Data bus drive enable |

## Verification
Two events can meet at one clock boundary. The first is the `done` cycle of a read, which is also the only idle cycle. The second is the acceptance of a following write, which would begin driving the bus. The bench provokes this by issuing the write in the very cycle `done` is seen. It then judges the result three ways: a bus model reports any clock where the memory and the controller drive at the same time, a monitor checks that no drive appears in the clock right after output enable was low, and the written byte is read back afterwards. A second collision is a request raised in the middle of a read. The bench judges it by checking that the controller stays idle after `done` and that the targeted byte is unchanged.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int ASR_AW = 17;
    localparam int ASR_DW = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WSET,
        ST_WPUL,
        ST_WHLD
    } st_e;

    // memory-side control levels for one state
    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } pins_t;

    // clocks needed to cover a time, never fewer than one
    function automatic int cyc_for(input int ns, input int per);
        int c;
        c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic pins_t pins_for(input st_e s);
        pins_t p;
        p = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        case (s)
            ST_RD:   p = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
            ST_WSET: p = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
            ST_WPUL: p = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
            ST_WHLD: p = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
            default: p = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/asram_capture.sv
module asram_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = ASR_AW,
    parameter int DATA_W        = ASR_DW,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_RC_NS       = 12,
    parameter int T_AA_NS       = 12,
    parameter int T_WC_NS       = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rdy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe
);
    localparam int RD_NS  = (T_RC_NS > T_AA_NS) ? T_RC_NS : T_AA_NS;
    localparam int RD_CYC = cyc_for(RD_NS, CLK_PERIOD_NS);
    localparam int WR_CYC = cyc_for(T_WC_NS, CLK_PERIOD_NS);
    localparam int MAXC   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int CNT_W  = $clog2(MAXC + 1);

    st_e               st, st_nxt;
    pins_t             pins_q;
    logic              done_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              tmr_load, tmr_zero, cap_en;
    logic [CNT_W-1:0]  tmr_val;

    // next state and wait-counter loading
    always_comb begin
        st_nxt   = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st)
            ST_IDLE: if (req) begin
                if (req_we) begin
                    st_nxt = ST_WSET;
                end else begin
                    st_nxt   = ST_RD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RD_CYC - 1);
                end
            end
            ST_RD:   if (tmr_zero) st_nxt = ST_IDLE;
            ST_WSET: begin
                st_nxt   = ST_WPUL;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WR_CYC - 1);
            end
            ST_WPUL: if (tmr_zero) st_nxt = ST_WHLD;
            ST_WHLD: st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    assign cap_en = (st == ST_RD) && tmr_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            pins_q  <= pins_for(ST_IDLE);
            done_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            st     <= st_nxt;
            pins_q <= pins_for(st_nxt);
            done_q <= cap_en || (st == ST_WHLD);
            if (st == ST_IDLE && req) begin
                addr_q <= req_addr;
                if (req_we)
                    wdata_q <= req_wdata;
            end
        end
    end

    asram_timer #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    asram_capture #(.W(DATA_W)) u_cap (
        .clk (clk),
        .rst (rst),
        .en  (cap_en),
        .d   (sram_dq_in),
        .q   (rdata)
    );

    assign rdy         = (st == ST_IDLE);
    assign done        = done_q;
    assign sram_ce1_n  = pins_q.ce1_n;
    assign sram_ce2    = pins_q.ce2;
    assign sram_we_n   = pins_q.we_n;
    assign sram_oe_n   = pins_q.oe_n;
    assign sram_dq_oe  = pins_q.dq_oe;
    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rdy,
    input logic              done,
    input logic [DATA_W-1:0] rdata,
    input logic              sram_ce1_n,
    input logic              sram_ce2,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              sram_dq_oe
);
    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (rst)
        rdy |-> (sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe)); // R1

    AST_IDLE_STATIC: assert property (@(posedge clk) disable iff (rst)
        (rdy && $past(rdy)) |-> ($stable(sram_addr) && $stable(sram_dq_out))); // R2

    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n || !$past(sram_we_n)) |-> ($stable(sram_dq_out) && sram_dq_oe)); // R4

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce1_n && !$past(sram_ce1_n)) |-> $stable(sram_addr)); // R5

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> sram_oe_n); // R6

    AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |=> !sram_dq_oe); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!sram_we_n && !sram_oe_n)); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rdata)); // R9
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rdy         (rdy),
    .done        (done),
    .rdata       (rdata),
    .sram_ce1_n  (sram_ce1_n),
    .sram_ce2    (sram_ce2),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;
    localparam int RD_LAT = 4;   // RD_CYC(3) + 1
    localparam int WR_LAT = 6;   // WR_CYC(3) + 3
    localparam int PULSE  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rdy, done;
    logic [7:0]  rdata;
    logic        ce1_n, ce2, we_n, oe_n, dq_oe;
    logic [16:0] maddr;
    logic [7:0]  dq_out, dq_in;

    always #10 clk = ~clk;

    asram_ctrl u_asram_ctrl (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rdy(rdy), .done(done), .rdata(rdata),
        .sram_ce1_n(ce1_n), .sram_ce2(ce2), .sram_we_n(we_n), .sram_oe_n(oe_n),
        .sram_addr(maddr), .sram_dq_out(dq_out), .sram_dq_in(dq_in), .sram_dq_oe(dq_oe)
    );

    // bus model: 512 cells chosen by {addr[16], addr[7:0]}; all test addresses differ there
    logic [7:0] mem [0:511];
    logic       mdrv;
    assign mdrv  = !ce1_n && ce2 && we_n && !oe_n;
    assign dq_in = mdrv ? mem[{maddr[16], maddr[7:0]}] : 8'hEE;

    always @(posedge we_n)
        if (ce1_n === 1'b0 && ce2 === 1'b1 && dq_oe === 1'b1)
            mem[{maddr[16], maddr[7:0]}] = dq_out;

    int n_chk = 0, n_err = 0;
    int v_cont = 0, v_turn = 0, v_oew = 0, v_wew = 0, v_oe_runs = 0, v_we_runs = 0;
    int oe_run = 0, we_run = 0;
    bit prev_oe_low = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // negedge monitors
    always @(negedge clk) if (!rst) begin
        if (dq_oe && mdrv) v_cont++;
        if (dq_oe && prev_oe_low) v_turn++;
        prev_oe_low = !oe_n;
        if (!oe_n) oe_run++;
        else if (oe_run != 0) begin
            if (oe_run != PULSE) v_oew++;
            v_oe_runs++;
            oe_run = 0;
        end
        if (!we_n) we_run++;
        else if (we_run != 0) begin
            if (we_run != PULSE) v_wew++;
            v_we_runs++;
            we_run = 0;
        end
    end

    task automatic finish_up;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_up();
    end

    // issue one op at the current negedge; returns at the negedge where done is seen
    task automatic do_op(input bit we, input logic [16:0] a, input logic [7:0] d,
                         input logic [7:0] exp);
        int lat;
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        chk(!rdy, "R7 rdy low while busy", rdy, 0);
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        if (we) begin
            chk(lat == WR_LAT, "R4 write latency", lat, WR_LAT);
            chk(!dq_oe && ce1_n, "R4 bus released at done", {dq_oe, ce1_n}, 2'b01);
        end else begin
            chk(lat == RD_LAT, "R3 read latency", lat, RD_LAT);
            chk(rdata == exp, "R3 read data", rdata, exp);
        end
    endtask

    // {we, addr, data-or-expected}
    localparam int NV = 12;
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 17'h00000, 8'h3C},
        {1'b1, 17'h1FFFF, 8'hA5},
        {1'b1, 17'h0AA55, 8'h00},
        {1'b1, 17'h10000, 8'hFF},
        {1'b0, 17'h00000, 8'h3C},
        {1'b0, 17'h1FFFF, 8'hA5},
        {1'b0, 17'h0AA55, 8'h00},
        {1'b0, 17'h10000, 8'hFF},
        {1'b1, 17'h00000, 8'h81},
        {1'b0, 17'h00000, 8'h81},
        {1'b0, 17'h00001, 8'h00},
        {1'b0, 17'h1FFFF, 8'hA5}
    };

    initial begin
        logic [16:0] a0;
        logic [7:0]  r0;
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ce1_n && !ce2 && we_n && oe_n && !dq_oe && rdy && !done,
            "R1 reset outputs", {ce1_n, ce2, we_n, oe_n, dq_oe, rdy, done}, 7'b1011010);
        rst = 1'b0;
        @(negedge clk);
        chk(ce1_n && !ce2 && rdy, "R1 idle after reset", {ce1_n, ce2, rdy}, 3'b101);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] prev_r;
            prev_r = rdata;
            do_op(VEC[i][25], VEC[i][24:8], VEC[i][7:0], VEC[i][7:0]);
            if (VEC[i][25]) chk(rdata == prev_r, "R9 rdata kept over write", rdata, prev_r);
            @(negedge clk);
            chk(!done && rdy, "R7 done one clock", {done, rdy}, 2'b01);
        end

        // R2 idle lines static
        a0 = maddr; r0 = dq_out;
        req_addr = 17'h12345; req_wdata = 8'h77;
        repeat (4) @(negedge clk);
        chk(maddr == a0 && dq_out == r0, "R2 idle address/data static", maddr, a0);
        chk(ce1_n && !ce2 && we_n && oe_n, "R1 standby while idle", {ce1_n, ce2}, 2'b10);

        // R6: write issued in the done cycle of a read
        do_op(1'b0, 17'h1FFFF, 8'h00, 8'hA5);
        do_op(1'b1, 17'h12345, 8'h5A, 8'h00);
        @(negedge clk);
        do_op(1'b0, 17'h12345, 8'h00, 8'h5A);
        chk(rdata == 8'h5A, "R6 back-to-back write landed", rdata, 8'h5A);
        @(negedge clk);

        // R7: request during a read is ignored
        req = 1'b1; req_we = 1'b0; req_addr = 17'h00000;
        @(posedge clk);
        @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 17'h00077; req_wdata = 8'h99;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(done && rdata == 8'h81, "R7 read unaffected by stray req", rdata, 8'h81);
        repeat (3) @(negedge clk);
        chk(rdy && ce1_n, "R7 stray req not started", {rdy, ce1_n}, 2'b11);
        do_op(1'b0, 17'h00077, 8'h00, 8'h00);
        @(negedge clk);

        chk(v_cont == 0, "R6 bus contention clocks", v_cont, 0);
        chk(v_turn == 0, "R6 drive right after oe low", v_turn, 0);
        chk(v_oew == 0 && v_oe_runs > 0, "R3 oe_n low width", v_oew, 0);
        chk(v_wew == 0 && v_we_runs > 0, "R4 we_n low width", v_wew, 0);
        chk(!(!we_n && !oe_n), "R8 strobes exclusive", {we_n, oe_n}, 2'b11);
        chk(maddr == 17'h00077, "R5 address held after access", maddr, 17'h00077);
        finish_up();
    end
endmodule